// File: doc/BRIEF.md
# Page-Aligned Flash Write Sequencer

This block writes an arbitrary byte range into a serial NOR flash by breaking it into page-program operations, none of which crosses a 256-byte page boundary. A client gives it a 24-bit start address and a byte count with a start pulse. It then pulls the payload from a valid/ready byte stream and drives a byte-level command port into a downstream SPI command engine.

For every chunk it runs the same sequence. It sends a write-enable frame, then a page-program frame that carries the address and the chunk's payload. It then polls the status register until the write-in-progress flag clears, and closes with a write-disable frame. A one-cycle done pulse reports the end of the request, and an error flag reports a rejected request or a poll timeout.

The command port carries one byte per handshake. `cmd_last_o` marks the final byte of a chip-select frame. `cmd_rd_o` marks a read slot, and the engine answers each read slot with one `rsp_valid_i` beat that carries bit 0 of the received status byte.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset `busy_o`, `done_o`, `err_o`, `cmd_valid_o` and `data_ready_o` are all 0.
- R2: Each chunk is sent as a fixed series of frames, encoded as {rd, last, byte}:
  - a write-enable frame: byte 0x06 with last=1;
  - a program frame: 0x02, then address bits 23:16, 15:8 and 7:0, then the chunk's data bytes, with last=1 only on the final data byte;
  - one or more status frames: 0x05 followed by a read slot of byte 0x00 with rd=1 and last=1;
  - a write-disable frame: 0x04 with last=1.
- R3: The chunk length is min(remaining length, 256 − (address mod 256)), so the first chunk ends on a page boundary and later chunks are min(256, remaining). After each chunk the address advances by the chunk length.
- R4: Status frames repeat while the returned write-in-progress bit (`rsp_wip_i`) is 1. The write-disable frame follows the first status read that returns 0.
- R5: If POLL_MAX status reads in one chunk all return 1, the request aborts. No further command bytes are sent, and `done_o` pulses with `err_o`=1.
- R6: `done_o` pulses for exactly one cycle, in the cycle after the last chunk's write-disable byte is accepted, with `err_o`=0.
- R7: A start with length 0 sends no command bytes and consumes no data. It produces a done pulse in the next cycle with `err_o`=1.
- R8: `data_ready_o` is high only during a chunk's data phase, where it equals `cmd_ready_i`. Data bytes pass to `cmd_data_o` in the same cycle, and exactly the requested number of bytes is consumed.
- R9: Outside the data phase, a presented command byte stays valid and unchanged while `cmd_ready_i` is low.
- R10: `start_i` is ignored while `busy_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, sampled when idle |
| addr_i | input | 24 | Flash start address |
| len_i | input | LEN_W | Byte count |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Error from last request (zero length or poll timeout) |
| data_i | input | 8 | Payload byte |
| data_valid_i | input | 1 | Payload byte valid |
| data_ready_o | output | 1 | Payload byte accepted |
| cmd_valid_o | output | 1 | Command byte valid |
| cmd_data_o | output | 8 | Command byte |
| cmd_last_o | output | 1 | Final byte of frame |
| cmd_rd_o | output | 1 | Byte is a read slot |
| cmd_ready_i | input | 1 | Engine accepts command byte |
| rsp_valid_i | input | 1 | Status read result valid |
| rsp_wip_i | input | 1 | Write-in-progress bit of status read |

## Verification
The bench aims at these corner cases, each with the failure it would expose:
- **Start addresses near page ends** (0xFF with one byte, 0x10 with 300 bytes, 0xF0 fitting inside one page). An off-by-one in the chunk computation would spill bytes into the next page or split a chunk needlessly.
- **Aligned full pages and multi-page runs.** A wrong formula would emit a zero-length or 257-byte chunk.
- **Random busy-poll depths.** These expose a sequencer that skips polling or sends write-disable early.
- **A poll count at the limit.** This must abort without a further frame.
- **A zero-length request.** It must emit nothing.
- **A second start pulse mid-request.** A design that restarts or reports an early error would corrupt the frame stream.

// File: rtl/fps_pkg.sv
package fps_pkg;
  localparam int ADDR_W = 24;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_PROG = 8'h02;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] RD_FILL = 8'h00;

  typedef enum logic [3:0] {
    S_IDLE,
    S_WREN,
    S_PP_OP,
    S_ADR_H,
    S_ADR_M,
    S_ADR_L,
    S_DATA,
    S_RS_OP,
    S_RS_RD,
    S_RS_WAIT,
    S_WRDI
  } fps_state_e;
endpackage

// File: rtl/fps_chunk_calc.sv
module fps_chunk_calc #(
  parameter int LEN_W  = 16,
  parameter int PAGE_W = 8
) (
  input  logic [PAGE_W-1:0] addr_lo_i,
  input  logic [LEN_W-1:0]  rem_i,
  output logic [PAGE_W:0]   chunk_o
);
  localparam int PAGE_BYTES = 1 << PAGE_W;

  logic [PAGE_W:0] room;

  always_comb begin
    room = (PAGE_W+1)'(PAGE_BYTES) - {1'b0, addr_lo_i};
    if (rem_i < LEN_W'(room)) chunk_o = rem_i[PAGE_W:0];
    else                      chunk_o = room;
  end
endmodule

// File: rtl/fps_poll_ctr.sv
module fps_poll_ctr #(
  parameter int POLL_MAX = 65535
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic at_limit_o
);
  localparam int CW = $clog2(POLL_MAX + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign at_limit_o = (cnt_q == CW'(POLL_MAX - 1));

  a_r5_poll_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(POLL_MAX));
endmodule

// File: rtl/fps_cmd_mux.sv
module fps_cmd_mux
  import fps_pkg::*;
(
  input  fps_state_e        state_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  input  logic              data_valid_i,
  input  logic              data_last_i,
  output logic              valid_o,
  output logic [7:0]        byte_o,
  output logic              last_o,
  output logic              rd_o
);
  always_comb begin
    valid_o = 1'b1;
    byte_o  = 8'h00;
    last_o  = 1'b0;
    rd_o    = 1'b0;
    unique case (state_i)
      S_WREN:  begin byte_o = OP_WREN; last_o = 1'b1; end
      S_PP_OP: byte_o = OP_PROG;
      S_ADR_H: byte_o = addr_i[23:16];
      S_ADR_M: byte_o = addr_i[15:8];
      S_ADR_L: byte_o = addr_i[7:0];
      S_DATA: begin
        valid_o = data_valid_i;
        byte_o  = data_i;
        last_o  = data_last_i;
      end
      S_RS_OP: byte_o = OP_RDSR;
      S_RS_RD: begin byte_o = RD_FILL; last_o = 1'b1; rd_o = 1'b1; end
      S_WRDI:  begin byte_o = OP_WRDI; last_o = 1'b1; end
      default: valid_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import fps_pkg::*;
#(
  parameter int LEN_W    = 16,
  parameter int PAGE_W   = 8,
  parameter int POLL_MAX = 65535
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [23:0]      addr_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  input  logic [7:0]       data_i,
  input  logic             data_valid_i,
  output logic             data_ready_o,
  output logic             cmd_valid_o,
  output logic [7:0]       cmd_data_o,
  output logic             cmd_last_o,
  output logic             cmd_rd_o,
  input  logic             cmd_ready_i,
  input  logic             rsp_valid_i,
  input  logic             rsp_wip_i
);
  localparam int PAGE_BYTES = 1 << PAGE_W;

  fps_state_e        state_q;
  logic [ADDR_W-1:0] cur_addr_q;
  logic [LEN_W-1:0]  rem_q;
  logic [PAGE_W:0]   byte_cnt_q;
  logic [PAGE_W:0]   chunk_len;
  logic              done_q, err_q;
  logic              fire, data_last, poll_at_limit;
  logic              poll_clr, poll_inc;

  fps_chunk_calc #(.LEN_W(LEN_W), .PAGE_W(PAGE_W)) u_chunk (
    .addr_lo_i (cur_addr_q[PAGE_W-1:0]),
    .rem_i     (rem_q),
    .chunk_o   (chunk_len)
  );

  assign poll_clr = (state_q == S_DATA) && fire && data_last;
  assign poll_inc = (state_q == S_RS_WAIT) && rsp_valid_i && rsp_wip_i && !poll_at_limit;

  fps_poll_ctr #(.POLL_MAX(POLL_MAX)) u_poll (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (poll_clr),
    .inc_i      (poll_inc),
    .at_limit_o (poll_at_limit)
  );

  assign data_last = ((byte_cnt_q + 1'b1) == chunk_len);

  fps_cmd_mux u_mux (
    .state_i      (state_q),
    .addr_i       (cur_addr_q),
    .data_i       (data_i),
    .data_valid_i (data_valid_i),
    .data_last_i  (data_last),
    .valid_o      (cmd_valid_o),
    .byte_o       (cmd_data_o),
    .last_o       (cmd_last_o),
    .rd_o         (cmd_rd_o)
  );

  assign fire         = cmd_valid_o && cmd_ready_i;
  assign data_ready_o = (state_q == S_DATA) && cmd_ready_i;
  assign busy_o       = (state_q != S_IDLE);
  assign done_o       = done_q;
  assign err_o        = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      cur_addr_q <= '0;
      rem_q      <= '0;
      byte_cnt_q <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          if (len_i == '0) begin
            done_q <= 1'b1;
            err_q  <= 1'b1;
          end else begin
            err_q      <= 1'b0;
            cur_addr_q <= addr_i;
            rem_q      <= len_i;
            state_q    <= S_WREN;
          end
        end
        S_WREN:  if (fire) state_q <= S_PP_OP;
        S_PP_OP: if (fire) state_q <= S_ADR_H;
        S_ADR_H: if (fire) state_q <= S_ADR_M;
        S_ADR_M: if (fire) state_q <= S_ADR_L;
        S_ADR_L: if (fire) begin
          byte_cnt_q <= '0;
          state_q    <= S_DATA;
        end
        S_DATA: if (fire) begin
          if (data_last) state_q <= S_RS_OP;
          else           byte_cnt_q <= byte_cnt_q + 1'b1;
        end
        S_RS_OP: if (fire) state_q <= S_RS_RD;
        S_RS_RD: if (fire) state_q <= S_RS_WAIT;
        S_RS_WAIT: if (rsp_valid_i) begin
          if (!rsp_wip_i)         state_q <= S_WRDI;
          else if (poll_at_limit) begin
            state_q <= S_IDLE;
            done_q  <= 1'b1;
            err_q   <= 1'b1;
          end else                state_q <= S_RS_OP;
        end
        S_WRDI: if (fire) begin
          if (rem_q == LEN_W'(chunk_len)) begin
            state_q <= S_IDLE;
            done_q  <= 1'b1;
          end else begin
            cur_addr_q <= cur_addr_q + ADDR_W'(chunk_len);
            rem_q      <= rem_q - LEN_W'(chunk_len);
            state_q    <= S_WREN;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R3: a data byte never lands past the end of its page
  a_r3_in_page: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_DATA) |->
      (({2'b00, cur_addr_q[PAGE_W-1:0]} + {1'b0, byte_cnt_q}) < (PAGE_W+2)'(PAGE_BYTES)));

  a_r6_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r7_zero_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && len_i == '0) |=> (done_o && err_o && !busy_o));

  a_r8_ready_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_ready_o |-> (cmd_ready_i && busy_o && !cmd_rd_o));

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_ready_i && state_q != S_DATA) |=>
      (cmd_valid_o && $stable(cmd_data_o) && $stable(cmd_last_o)));
endmodule

// File: tb/flash_prog_seq_tb.sv
module flash_prog_seq_tb;
  localparam int LEN_W = 16;
  localparam int POLL  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic             start_i = 1'b0;
  logic [23:0]      addr_i = '0;
  logic [LEN_W-1:0] len_i = '0;
  logic             busy_o, done_o, err_o;
  logic [7:0]       data_i = '0;
  logic             data_valid_i = 1'b0;
  logic             data_ready_o;
  logic             cmd_valid_o, cmd_last_o, cmd_rd_o;
  logic [7:0]       cmd_data_o;
  logic             cmd_ready_i = 1'b0;
  logic             rsp_valid_i = 1'b0;
  logic             rsp_wip_i = 1'b0;

  flash_prog_seq #(.LEN_W(LEN_W), .PAGE_W(8), .POLL_MAX(POLL)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .addr_i(addr_i), .len_i(len_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .data_i(data_i), .data_valid_i(data_valid_i), .data_ready_o(data_ready_o),
    .cmd_valid_o(cmd_valid_o), .cmd_data_o(cmd_data_o), .cmd_last_o(cmd_last_o),
    .cmd_rd_o(cmd_rd_o), .cmd_ready_i(cmd_ready_i),
    .rsp_valid_i(rsp_valid_i), .rsp_wip_i(rsp_wip_i)
  );

  logic [7:0] stream [0:1023];
  logic [9:0] cap    [0:4095];
  logic [9:0] expv   [0:4095];
  int ncap, nexp, sidx, done_cnt, op_busy, busy_left, exp_used;
  bit err_seen, exp_err, pend, frame_start;
  int checks = 0, fails = 0;

  task automatic chk(bit ok, string req, string what, int act, int expd);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expd);
    end
  endtask

  task automatic push(logic [9:0] v);
    if (nexp < 4096) begin expv[nexp] = v; nexp++; end
  endtask

  // expected frame stream built from R2..R5
  task automatic build_exp(int addr, int len, int busy);
    int a, rem, c, pos, reads;
    nexp = 0; a = addr; rem = len; pos = 0; exp_err = 0;
    while (rem > 0 && !exp_err) begin
      c = 256 - (a % 256);
      if (rem < c) c = rem;
      push({2'b01, 8'h06});
      push({2'b00, 8'h02});
      push({2'b00, 8'(a >> 16)});
      push({2'b00, 8'(a >> 8)});
      push({2'b00, 8'(a)});
      for (int k = 0; k < c; k++) begin
        push({1'b0, (k == c - 1), stream[pos]});
        pos++;
      end
      reads = busy + 1;
      if (busy >= POLL) begin reads = POLL; exp_err = 1; end
      for (int k = 0; k < reads; k++) begin
        push({2'b00, 8'h05});
        push({2'b11, 8'h00});
      end
      if (!exp_err) push({2'b01, 8'h04});
      a = (a + c) % (1 << 24);
      rem -= c;
    end
    exp_used = pos;
    if (len == 0) exp_err = 1;
  endtask

  // engine and stream model
  initial begin
    forever begin
      @(negedge clk);
      cmd_ready_i  = ($urandom % 4) != 0;
      data_valid_i = ($urandom % 4) != 0;
      data_i       = stream[sidx % 1024];
      if (pend) begin
        rsp_valid_i = 1'b1;
        rsp_wip_i   = (busy_left > 0);
        if (busy_left > 0) busy_left--;
        pend = 0;
      end else begin
        rsp_valid_i = 1'b0;
        rsp_wip_i   = 1'($urandom);
      end
      #1;
      if (done_o) begin done_cnt++; err_seen = err_o; end
      if (cmd_valid_o && cmd_ready_i) begin
        if (frame_start && cmd_data_o == 8'h06 && cmd_last_o) busy_left = op_busy;
        if (ncap < 4096) begin cap[ncap] = {cmd_rd_o, cmd_last_o, cmd_data_o}; ncap++; end
        if (cmd_rd_o) pend = 1;
        frame_start = cmd_last_o;
        if (data_ready_o && data_valid_i) sidx++;
      end
    end
  end

  task automatic run_op(int addr, int len, int busy, bit extra_start, string tag);
    int to, bad;
    for (int i = 0; i < 1024; i++) stream[i] = 8'($urandom);
    sidx = 0; ncap = 0; done_cnt = 0; err_seen = 0; frame_start = 1;
    op_busy = busy; busy_left = busy; pend = 0;
    build_exp(addr, len, busy);
    @(negedge clk);
    addr_i = 24'(addr); len_i = LEN_W'(len); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (extra_start) begin
      repeat (20) @(negedge clk);
      len_i = '0; addr_i = 24'h000123; start_i = 1'b1;   // R10: ignored while busy
      @(negedge clk);
      start_i = 1'b0;
    end
    to = 0;
    while (busy_o && to < 60000) begin @(negedge clk); to++; end
    repeat (4) @(negedge clk);
    chk(ncap == nexp, "R2", {tag, " frame byte count"}, ncap, nexp);
    bad = -1;
    for (int i = 0; i < nexp && i < ncap; i++)
      if (bad < 0 && cap[i] !== expv[i]) bad = i;
    if (bad >= 0)
      chk(0, "R3", {tag, " byte mismatch (index in msg is value)"}, int'(cap[bad]), int'(expv[bad]));
    else
      chk(1, "R3", tag, 0, 0);
    chk(done_cnt == 1, "R6", {tag, " done pulse cycles"}, done_cnt, 1);
    chk(err_seen == exp_err, exp_err ? "R5" : "R4", {tag, " err flag"}, int'(err_seen), int'(exp_err));
    chk(sidx == exp_used, "R8", {tag, " stream bytes consumed"}, sidx, exp_used);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !err_o && !cmd_valid_o && !data_ready_o, "R1",
        "outputs in reset", int'({busy_o, done_o, err_o, cmd_valid_o, data_ready_o}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy_o && !cmd_valid_o && !data_ready_o, "R1", "idle after reset",
        int'({busy_o, cmd_valid_o, data_ready_o}), 0);

    run_op(24'h000100, 256, 0, 0, "R3 aligned page");
    run_op(24'h002000, 512, 1, 0, "R3 two pages");
    run_op(24'h0000FF, 1, 0, 0, "R3 last byte of page");
    run_op(24'h000010, 300, 2, 0, "R3 split 240+60");
    run_op(24'h0300F0, 10, 3, 0, "R3 inside page");
    run_op(24'h123456, 1, 1, 0, "R2 single byte");
    run_op(24'h000000, 0, 0, 0, "R7 zero length");
    chk(ncap == 0, "R7", "no commands for zero length", ncap, 0);
    run_op(24'h004080, 200, POLL, 0, "R5 poll limit");
    run_op(24'h004080, 200, POLL - 1, 0, "R4 poll just under limit");
    run_op(24'h0500C0, 400, 1, 1, "R10 start while busy");
    chk(!err_o, "R10", "err after ignored start", int'(err_o), 0);
    for (int n = 0; n < 6; n++) begin
      int a, l, b;
      a = int'($urandom % 24'hFFF000);
      l = 1 + int'($urandom % 600);
      b = int'($urandom % 4);
      run_op(a, l, b, 0, "R9 random");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule